// File: doc/BRIEF.md
# Conversion Counter with Clock Prescaler and Test Controls

The block counts ticks of an internal clock for one conversion after another. The internal clock comes from the raw oscillator. When `osc_sel` is high, every raw clock is a tick. When `osc_sel` is low, a prescaler lets through one tick in every 58 raw clocks. Ticks are carried as a one-cycle enable (`clk_en`), so the whole block works on the single raw clock. A running binary counter advances on each tick. A window counter marks integration windows of exactly 2048 ticks. At the end of each window, a one-cycle latch strobe copies the new count into an output latch register.

Two controls let the counter be frozen, forced, stepped and observed: `run_hold` and a three-level test input encoded on two bits. At the mid level the latched output follows the live count. With run/hold low and test low, the counter is forced to all ones and the internal clock is gated off. Releasing both controls, then applying one raw clock, clears the counter to zero.

A finite state machine holds the mode. It has three states:

- **ST_RUN**: the counter counts.
- **ST_HOLD**: the counter is frozen and the internal clock keeps running.
- **ST_FORCE**: the counter is all ones and the internal clock is off.

Its transitions are:

- **T_PAUSE**: RUN→HOLD, when run/hold is low and test is not low.
- **T_RESUME**: HOLD→RUN, when run/hold is high.
- **T_FORCE**: RUN or HOLD→FORCE, when run/hold is low and test is low.
- **T_RELEASE**: FORCE→RUN, when run/hold is high and test is not low. This is also the edge that clears the count.

Top module: `conv_counter`

## Requirements
- R1: With `osc_sel`=1 and the block in ST_RUN with `run_hold`=1, `clk_en` is 1 in every cycle and `count` rises by one at every raw clock edge, wrapping modulo 2^CNT_W.
- R2: With `osc_sel`=0, `clk_en` is a one-cycle pulse once every 58 raw clocks, and `count` advances only at edges where `clk_en` is 1.
- R3: Every 2048th tick counted in ST_RUN ends a window. At that edge the latch register takes the new count value. The window restarts from zero after reset and after T_RELEASE.
- R4: With `test_lvl`=2'b01 (mid), `count_q` equals the live `count` in every cycle.
- R5: With `test_lvl` equal to 2'b10 or 2'b11 (high), or 2'b00 (low), `count_q` shows the latch register. It changes only at a window end.
- R6: If `run_hold`=0 and `test_lvl`≠2'b00, then at the next edge the block enters ST_HOLD. It stays there while `run_hold` is 0. In ST_HOLD `count` is frozen and `clk_en` keeps its normal pattern.
- R7: If `run_hold`=0 and `test_lvl`=2'b00, then from the next edge `count` is all ones and `clk_en` is 0. The prescaler is held at its start, so after release the first divided tick comes 58 raw clocks later.
- R8: In ST_FORCE, the first raw clock edge with `run_hold`=1 and `test_lvl`≠2'b00 sets `count` to zero and returns the block to ST_RUN.
- R9: A synchronous active-low `rst_n` clears the count, the latch register, the window counter and the prescaler, and enters ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock; the only clock of the block |
| rst_n | input | 1 | Synchronous reset, active low |
| osc_sel | input | 1 | 1: tick on every raw clock; 0: tick once per 58 raw clocks |
| run_hold | input | 1 | 1: run; 0: hold, or force when test is low |
| test_lvl | input | 2 | Test level: 00 low, 01 mid, 10/11 high |
| count | output | CNT_W | Live conversion counter |
| count_q | output | CNT_W | Latched count, transparent when the test level is mid |
| clk_en | output | 1 | Internal-clock enable (one pulse per tick) |

## Verification
A wrong state register shows up at once. `count` would move in ST_HOLD, would not read all ones in ST_FORCE, or `clk_en` would not drop one cycle after the force condition appears. A prescaler or window counter that is off by one is slower to show. The prescaler error appears as a `clk_en` pulse displaced within 58 cycles. The window error appears as a wrong `count_q` value at the next window end, up to 2048 ticks later. A cycle-by-cycle reference model therefore compares all three outputs on every clock, across random mode changes.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FORCE = 2'd2
    } cc_state_e;

    typedef enum logic [1:0] {
        TL_LOW   = 2'b00,
        TL_MID   = 2'b01,
        TL_HIGH  = 2'b10,
        TL_HIGH2 = 2'b11
    } cc_test_e;
endpackage

// File: rtl/cc_prescale.sv
module cc_prescale #(
    parameter int DIV = 58
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bypass,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pcnt_q <= '0;
        end else if (pcnt_q == LAST) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + PW'(1);
        end
    end

    assign tick = bypass || (pcnt_q == LAST);

    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && $past(!bypass) && $past(tick)) |-> !tick); // R2
endmodule

// File: rtl/cc_fsm.sv
module cc_fsm
    import cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_hold,
    input  logic [1:0] test_lvl,
    output cc_state_e state,
    output logic      ld_ones,
    output logic      ld_zero,
    output logic      run_ok,
    output logic      gated
);
    cc_state_e state_q;
    logic force_req;
    logic release_req;

    assign force_req   = !run_hold && (test_lvl == TL_LOW);
    assign release_req = run_hold && (test_lvl != TL_LOW);

    // state register with transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (force_req)      state_q <= ST_FORCE;   // T_FORCE
                    else if (!run_hold) state_q <= ST_HOLD;    // T_PAUSE
                end
                ST_HOLD: begin
                    if (force_req)      state_q <= ST_FORCE;   // T_FORCE
                    else if (run_hold)  state_q <= ST_RUN;     // T_RESUME
                end
                ST_FORCE: begin
                    if (release_req)    state_q <= ST_RUN;     // T_RELEASE
                end
                default:                state_q <= ST_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        ld_ones = 1'b0;
        ld_zero = 1'b0;
        run_ok  = 1'b0;
        gated   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                ld_ones = force_req;
                run_ok  = run_hold;
            end
            ST_HOLD: begin
                ld_ones = force_req;
            end
            ST_FORCE: begin
                gated   = 1'b1;
                ld_zero = release_req;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/cc_counter.sv
module cc_counter #(
    parameter int CNT_W = 16,
    parameter int WIN   = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_ones,
    input  logic             ld_zero,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] lat,
    output logic             strobe
);
    localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [WW-1:0] WLAST = WW'(WIN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lat_q;
    logic [WW-1:0]    win_q;

    assign strobe = adv && (win_q == WLAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lat_q <= '0;
            win_q <= '0;
        end else if (ld_ones) begin
            cnt_q <= '1;
            win_q <= '0;
        end else if (ld_zero) begin
            cnt_q <= '0;
            win_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (strobe) begin
                win_q <= '0;
                lat_q <= cnt_q + CNT_W'(1);
            end else begin
                win_q <= win_q + WW'(1);
            end
        end
    end

    assign cnt = cnt_q;
    assign lat = lat_q;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(lat_q)); // R5
endmodule

// File: rtl/conv_counter.sv
module conv_counter
    import cc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int WIN   = 2048,
    parameter int DIV   = 58
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             osc_sel,
    input  logic             run_hold,
    input  logic [1:0]       test_lvl,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_q,
    output logic             clk_en
);
    cc_state_e        st;
    logic             ld_ones, ld_zero, run_ok, gated;
    logic             raw_tick, strobe;
    logic [CNT_W-1:0] lat;

    cc_fsm u_fsm (
        .clk(clk_osc), .rst_n(rst_n), .run_hold(run_hold), .test_lvl(test_lvl),
        .state(st), .ld_ones(ld_ones), .ld_zero(ld_zero), .run_ok(run_ok), .gated(gated)
    );

    cc_prescale #(.DIV(DIV)) u_pre (
        .clk(clk_osc), .rst_n(rst_n), .clr(gated), .bypass(osc_sel), .tick(raw_tick)
    );

    cc_counter #(.CNT_W(CNT_W), .WIN(WIN)) u_cnt (
        .clk(clk_osc), .rst_n(rst_n), .ld_ones(ld_ones), .ld_zero(ld_zero),
        .adv(run_ok && raw_tick), .cnt(count), .lat(lat), .strobe(strobe)
    );

    assign clk_en  = raw_tick && !gated;
    assign count_q = (test_lvl == TL_MID) ? count : lat;

    AST_FORCE_ONES: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (st == ST_FORCE) |-> (&count)); // R7
    AST_RELEASE_ZERO: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ($past(st == ST_FORCE) && st == ST_RUN) |-> (count == '0)); // R8
    AST_HOLD_FROZEN: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ($past(st == ST_HOLD) && st == ST_HOLD) |-> $stable(count)); // R6
    AST_STROBE_RUN: assert property (@(posedge clk_osc) disable iff (!rst_n)
        strobe |-> (st == ST_RUN && run_hold)); // R3
endmodule

// File: tb/conv_counter_tb_top.sv
`timescale 1ns/1ps
module conv_counter_tb_top;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_sel = 1'b1;
    logic          run_hold = 1'b1;
    logic [1:0]    test_lvl = 2'b10;
    logic [CW-1:0] count, count_q;
    logic          clk_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    conv_counter dut_i (
        .clk_osc(clk), .rst_n(rst_n), .osc_sel(osc_sel), .run_hold(run_hold),
        .test_lvl(test_lvl), .count(count), .count_q(count_q), .clk_en(clk_en)
    );

    // reference model: 0 run, 1 hold, 2 force
    int            m_st = 0;
    int            m_pc = 0;
    int            m_win = 0;
    logic [CW-1:0] m_cnt = '0;
    logic [CW-1:0] m_lat = '0;
    bit            m_valid = 1'b0;
    bit            m_rst = 1'b0;
    bit            m_rel = 1'b0;
    bit            m_strb = 1'b0;

    always @(posedge clk) begin
        int  old_st;
        bit  tk, freq;
        old_st = m_st;
        m_rel = 1'b0; m_strb = 1'b0; m_rst = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_pc = 0; m_win = 0; m_cnt = '0; m_lat = '0;
            m_valid = 1'b1; m_rst = 1'b1;
        end else begin
            tk   = (osc_sel || m_pc == 57) && (m_st != 2);
            freq = !run_hold && (test_lvl == 2'b00);
            case (m_st)
                0: if (freq) begin m_st = 2; m_cnt = '1; m_win = 0; end
                   else if (!run_hold) m_st = 1;
                   else if (tk) begin
                       m_cnt = m_cnt + 1'b1;
                       if (m_win == 2047) begin m_win = 0; m_lat = m_cnt; m_strb = 1'b1; end
                       else m_win = m_win + 1;
                   end
                1: if (freq) begin m_st = 2; m_cnt = '1; m_win = 0; end
                   else if (run_hold) m_st = 0;
                default: if (run_hold && test_lvl != 2'b00) begin
                       m_st = 0; m_cnt = '0; m_win = 0; m_rel = 1'b1;
                   end
            endcase
            if (old_st == 2) m_pc = 0;
            else m_pc = (m_pc == 57) ? 0 : m_pc + 1;
        end
    end

    function automatic string cnt_tag();
        if (m_rst) return "R9";
        if (m_rel) return "R8";
        if (m_st == 2) return "R7";
        if (m_st == 1) return "R6";
        return osc_sel ? "R1" : "R2";
    endfunction

    function automatic string q_tag();
        if (m_rst) return "R9";
        if (m_strb) return "R3";
        return (test_lvl == 2'b01) ? "R4" : "R5";
    endfunction

    function automatic string en_tag();
        if (m_st == 2) return "R7";
        return osc_sel ? "R1" : "R2";
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [CW-1:0] eq;
        bit ee;
        if (!m_valid) return;
        eq = (test_lvl == 2'b01) ? m_cnt : m_lat;
        ee = (m_st != 2) && (osc_sel || m_pc == 57);
        chk(cnt_tag(), "count", count, m_cnt);
        chk(q_tag(), "count_q", count_q, eq);
        chk(en_tag(), "clk_en", clk_en, ee);
    endtask

    task automatic run_n(input int n);
        repeat (n) begin @(negedge clk); compare(); end
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd20250611);
        // R9: reset state
        run_n(4);
        rst_n = 1'b1;
        // R1 and R3: direct mode, several windows, test high
        run_n(5000);
        // R4: transparent latch
        test_lvl = 2'b01; run_n(300);
        test_lvl = 2'b11; run_n(100);
        // R6: hold
        run_hold = 1'b0; run_n(50);
        run_hold = 1'b1; run_n(20);
        // R7 then R8: force and single-clock release
        run_hold = 1'b0; test_lvl = 2'b00; run_n(10);
        test_lvl = 2'b01; run_n(5);          // still forced: run_hold low
        run_hold = 1'b1; run_n(1);           // release edge: count to zero
        run_n(2100);                         // R3 window restarted
        // R2: divided clock
        osc_sel = 1'b0; test_lvl = 2'b10; run_n(3000);
        run_hold = 1'b0; test_lvl = 2'b00; run_n(70);
        run_hold = 1'b1; test_lvl = 2'b10; run_n(200);
        // random mix
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); compare();
            if ($urandom_range(199) == 0) run_hold = ~run_hold;
            if ($urandom_range(299) == 0) test_lvl = 2'($urandom_range(3));
            if ($urandom_range(2999) == 0) osc_sel = ~osc_sel;
        end
        // R9: reset in the middle of operation
        osc_sel = 1'b1; run_hold = 1'b1; test_lvl = 2'b01;
        run_n(100);
        rst_n = 1'b0; run_n(3);
        rst_n = 1'b1; run_n(100);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule